// File: doc/BRIEF.md
# Bus Tenure Busy-Line Controller

This block sits on the master side of a shared bus whose owner signals its tenure on an open, bidirectional busy line. A local master raises a request when it wants to run a bus cycle. The controller watches the grant, transfer-start and busy lines. It takes the bus only when the bus is granted and free. It announces ownership by driving busy together with the first transfer-start. It keeps busy asserted across cycles for as long as grant allows. When it lets go, it releases the line in a fixed two-step order.

All bus lines are active-low. The busy line is modelled as three ports: a sampled input, a driven value and an output enable. Bus decisions are taken only on core clock edges where `clk_en` is high, so the bus can run at a fraction of the core rate. The final release step always lasts exactly one core clock.

The states are as follows. ST_IDLE is not owner, with the line an input. ST_START drives transfer-start and busy. ST_RUN is a cycle in progress. ST_PARK is owner with no cycle. ST_RELEASE drives busy high for one core clock. ST_HOLDOFF is not owner and waiting out the post-release samples.

The transitions are as follows. IDLE goes to START on a free, granted bus with a request. START goes to RUN on the next enabled edge. RUN goes back to START when the cycle is done with grant and request both present. RUN goes to PARK when the cycle is done with grant present and no request. RUN goes to RELEASE when the cycle is done and grant is gone. PARK goes to RELEASE when grant is gone, and to START when a request is present. RELEASE always goes to HOLDOFF. HOLDOFF goes to IDLE after `HOLDOFF_SAMPLES` enabled edges.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: Bus inputs, the request and `xfer_done` are acted on only at core clock edges where `clk_en` is 1. An edge with `clk_en` 0 changes nothing except the one-clock release step of R6 and reset.
- R2: From the not-owner state, ownership is taken only when `req` is 1, `grant_n` is 0, `ts_in_n` is 1 and `busy_in_n` is 1 at an enabled edge. After such an edge, `owner` is 1.
- R3: From the cycle after the taking edge, `ts_out_n` is 0 together with `busy_out_n` 0 and `busy_oe` 1. `ts_out_n` stays 0 until the next enabled edge and is 1 afterwards.
- R4: While owner, `busy_out_n` stays 0 with `busy_oe` 1 until an enabled edge at which `grant_n` is 1 and no cycle is running. A cycle is running from the end of the transfer-start to the enabled edge at which `xfer_done` is 1.
- R5: If a cycle ends at an enabled edge with `grant_n` 0 and `req` 1, the next transfer-start follows directly and `busy_out_n` is never driven high in between.
- R6: On release, `busy_oe` stays 1 with `busy_out_n` 1 for exactly one core clock. After that, `busy_oe` is 0 and `owner` is 0.
- R7: After a release, at least `HOLDOFF_SAMPLES` enabled edges (default 1) pass before an enabled edge can take the bus again.
- R8: During and directly after reset, `busy_oe` is 0, `owner` is 0, `ts_out_n` is 1 and `busy_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Bus clock enable; bus decisions only on edges with it high |
| req | input | 1 | Local master wants to run a bus cycle |
| xfer_done | input | 1 | Current bus cycle completes at this enabled edge |
| grant_n | input | 1 | Bus grant from the arbiter, active low |
| ts_in_n | input | 1 | Sampled transfer-start line, active low |
| busy_in_n | input | 1 | Sampled busy line, active low |
| busy_out_n | output | 1 | Value driven on the busy line, active low |
| busy_oe | output | 1 | Busy line driver enable |
| ts_out_n | output | 1 | Transfer-start drive, active low |
| owner | output | 1 | Block currently holds the bus |

## Verification
All outputs decode the single state register, so each result is due in the first core cycle after the edge that sampled its cause. For an enabled-edge decision that means one cycle after the enabled edge, and for the release step it means exactly one cycle after entering it. The bench drives inputs just after a falling edge and compares every output against a behavioural model at the next falling edge, half a period after the deciding rising edge. Directed steps with hand-worked values cover slow enables, back-to-back tenure, a grant withdrawn mid-cycle, blocked takes and the hold-off, and a long randomized run follows them.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_RUN     = 3'd2,
        ST_PARK    = 3'd3,
        ST_RELEASE = 3'd4,
        ST_HOLDOFF = 3'd5
    } tenure_state_e;

endpackage

// File: rtl/bus_free_sense.sv
module bus_free_sense (
    input  logic grant_n,
    input  logic ts_in_n,
    input  logic busy_in_n,
    output logic grant_on,
    output logic bus_free
);

    // Bus is free for us: granted, no transfer starting, nobody holding busy.
    always_comb begin
        grant_on = ~grant_n;
        bus_free = ~grant_n & ts_in_n & busy_in_n;
    end

endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
    import bus_tenure_pkg::*;
#(
    parameter int HOLDOFF_SAMPLES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          req,
    input  logic          xfer_done,
    input  logic          grant_on,
    input  logic          bus_free,
    output tenure_state_e state
);

    localparam int CW = $clog2(HOLDOFF_SAMPLES + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLDOFF_SAMPLES);
    localparam logic [CW-1:0] HOLD_LAST = CW'(1);

    tenure_state_e state_nx;
    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] hold_cnt_nx;

    always_comb begin
        state_nx    = state;
        hold_cnt_nx = hold_cnt;
        unique case (state)
            ST_IDLE: begin
                if (clk_en && req && bus_free)
                    state_nx = ST_START;
            end
            ST_START: begin
                if (clk_en)
                    state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (clk_en && xfer_done) begin
                    if (grant_on && req)
                        state_nx = ST_START;
                    else if (grant_on)
                        state_nx = ST_PARK;
                    else
                        state_nx = ST_RELEASE;
                end
            end
            ST_PARK: begin
                if (clk_en) begin
                    if (!grant_on)
                        state_nx = ST_RELEASE;
                    else if (req)
                        state_nx = ST_START;
                end
            end
            ST_RELEASE: begin
                // One core clock only, regardless of clk_en.
                state_nx    = ST_HOLDOFF;
                hold_cnt_nx = HOLD_LOAD;
            end
            ST_HOLDOFF: begin
                if (clk_en) begin
                    hold_cnt_nx = hold_cnt - HOLD_LAST;
                    if (hold_cnt == HOLD_LAST)
                        state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
        end else begin
            state    <= state_nx;
            hold_cnt <= hold_cnt_nx;
        end
    end

endmodule

// File: rtl/line_drive.sv
module line_drive
    import bus_tenure_pkg::*;
(
    input  tenure_state_e state,
    output logic          busy_out_n,
    output logic          busy_oe,
    output logic          ts_out_n,
    output logic          owner
);

    always_comb begin
        busy_out_n = 1'b1;
        busy_oe    = 1'b0;
        ts_out_n   = 1'b1;
        owner      = 1'b0;
        unique case (state)
            ST_IDLE, ST_HOLDOFF: begin
                // Line is an input; defaults hold.
            end
            ST_START: begin
                busy_out_n = 1'b0;
                busy_oe    = 1'b1;
                ts_out_n   = 1'b0;
                owner      = 1'b1;
            end
            ST_RUN, ST_PARK: begin
                busy_out_n = 1'b0;
                busy_oe    = 1'b1;
                owner      = 1'b1;
            end
            ST_RELEASE: begin
                busy_out_n = 1'b1;
                busy_oe    = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
    import bus_tenure_pkg::*;
#(
    parameter int HOLDOFF_SAMPLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic req,
    input  logic xfer_done,
    input  logic grant_n,
    input  logic ts_in_n,
    input  logic busy_in_n,
    output logic busy_out_n,
    output logic busy_oe,
    output logic ts_out_n,
    output logic owner
);

    logic          grant_on;
    logic          bus_free;
    tenure_state_e state;

    bus_free_sense u_sense (
        .grant_n   (grant_n),
        .ts_in_n   (ts_in_n),
        .busy_in_n (busy_in_n),
        .grant_on  (grant_on),
        .bus_free  (bus_free)
    );

    tenure_fsm #(
        .HOLDOFF_SAMPLES (HOLDOFF_SAMPLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .req       (req),
        .xfer_done (xfer_done),
        .grant_on  (grant_on),
        .bus_free  (bus_free),
        .state     (state)
    );

    line_drive u_drive (
        .state      (state),
        .busy_out_n (busy_out_n),
        .busy_oe    (busy_oe),
        .ts_out_n   (ts_out_n),
        .owner      (owner)
    );

endmodule

// File: rtl/bus_tenure_ctrl_chk.sv
module bus_tenure_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic req,
    input logic grant_n,
    input logic ts_in_n,
    input logic busy_in_n,
    input logic busy_out_n,
    input logic busy_oe,
    input logic ts_out_n,
    input logic owner
);

    assert_take_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner) |-> $past(clk_en && req && !grant_n && ts_in_n && busy_in_n));

    assert_ts_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_out_n |-> (busy_oe && !busy_out_n && owner));

    assert_hold_while_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner && !grant_n) |=> owner);

    assert_release_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_oe && busy_out_n) |=> !busy_oe);

    assert_release_drives_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_oe) |-> $past(busy_out_n));

    assert_no_instant_retake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_oe) |=> !owner);

    // R8: an undriven line is never reported as owned.
    always_comb begin
        if (rst_n) begin
            assert_no_owner_without_drive_R8: assert (!owner || busy_oe);
        end
    end

endmodule

bind bus_tenure_ctrl bus_tenure_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .req        (req),
    .grant_n    (grant_n),
    .ts_in_n    (ts_in_n),
    .busy_in_n  (busy_in_n),
    .busy_out_n (busy_out_n),
    .busy_oe    (busy_oe),
    .ts_out_n   (ts_out_n),
    .owner      (owner)
);

// File: tb/test_bus_tenure_ctrl.sv
module test_bus_tenure_ctrl;

    localparam int HOLD = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0;
    logic req = 1'b0;
    logic xfer_done = 1'b0;
    logic grant_n = 1'b1;
    logic ts_in_n = 1'b1;
    logic busy_in_n = 1'b1;
    logic busy_out_n, busy_oe, ts_out_n, owner;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    bus_tenure_ctrl #(.HOLDOFF_SAMPLES(HOLD)) i_bus_tenure_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .req        (req),
        .xfer_done  (xfer_done),
        .grant_n    (grant_n),
        .ts_in_n    (ts_in_n),
        .busy_in_n  (busy_in_n),
        .busy_out_n (busy_out_n),
        .busy_oe    (busy_oe),
        .ts_out_n   (ts_out_n),
        .owner      (owner)
    );

    // Behavioural reference: tenure flags and a hold-off sample count.
    bit m_own, m_ts, m_cyc, m_rel;
    int m_wait;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_own = 0; m_ts = 0; m_cyc = 0; m_rel = 0; m_wait = 0;
        end else if (m_rel) begin
            m_rel = 0;
            m_wait = HOLD;
        end else if (m_own) begin
            if (clk_en) begin
                if (m_ts) begin
                    m_ts = 0;
                    m_cyc = 1;
                end else if (m_cyc) begin
                    if (xfer_done) begin
                        m_cyc = 0;
                        if (!grant_n && req) m_ts = 1;
                        else if (grant_n) begin m_own = 0; m_rel = 1; end
                    end
                end else begin
                    if (grant_n) begin m_own = 0; m_rel = 1; end
                    else if (req) m_ts = 1;
                end
            end
        end else if (m_wait > 0) begin
            if (clk_en) m_wait = m_wait - 1;
        end else if (clk_en && req && !grant_n && ts_in_n && busy_in_n) begin
            m_own = 1;
            m_ts = 1;
        end
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check1("R2 owner vs model", owner, m_own);
        check1("R3 ts_out_n vs model", ts_out_n, !m_ts);
        check1("R4 busy_out_n vs model", busy_out_n, !m_own);
        check1("R6 busy_oe vs model", busy_oe, m_own | m_rel);
    endtask

    // Apply inputs after a falling edge, then compare at the next falling edge.
    task automatic step(input logic ce, input logic gn, input logic tsn,
                        input logic bsn, input logic rq, input logic dn);
        clk_en = ce; grant_n = gn; ts_in_n = tsn; busy_in_n = bsn;
        req = rq; xfer_done = dn;
        @(negedge clk);
        compare_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check1("R8 reset busy_oe", busy_oe, 1'b0);
        check1("R8 reset owner", owner, 1'b0);
        check1("R8 reset ts_out_n", ts_out_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R8 after reset busy_out_n", busy_out_n, 1'b1);

        // R1: free bus and request, but no enabled edge.
        step(0, 0, 1, 1, 1, 0);
        step(0, 0, 1, 1, 1, 0);
        check1("R1 no take without clk_en", owner, 1'b0);
        // Enabled edge takes the bus.
        step(1, 0, 1, 1, 1, 0);
        check1("R2 taken", owner, 1'b1);
        check1("R3 ts low on take", ts_out_n, 1'b0);
        check1("R3 busy low on take", busy_out_n, 1'b0);
        step(1, 0, 1, 1, 1, 0);
        check1("R3 ts one bus period", ts_out_n, 1'b1);
        // R5: cycle done with grant and request: straight into next start.
        step(1, 0, 1, 1, 1, 1);
        check1("R5 next ts", ts_out_n, 1'b0);
        check1("R5 busy held", busy_out_n, 1'b0);
        step(1, 0, 1, 1, 0, 0);
        // R4: grant removed mid-cycle, cycle still running.
        step(1, 1, 1, 1, 0, 0);
        check1("R4 busy held in cycle", busy_out_n, 1'b0);
        check1("R4 still owner", owner, 1'b1);
        // Cycle ends: release step.
        step(1, 1, 1, 1, 0, 1);
        check1("R6 release drives high", busy_out_n, 1'b1);
        check1("R6 release drives", busy_oe, 1'b1);
        step(1, 0, 1, 1, 1, 0);
        check1("R6 then tri-state", busy_oe, 1'b0);
        step(1, 0, 1, 1, 1, 0);
        check1("R7 hold-off sample", owner, 1'b0);
        step(1, 0, 1, 1, 1, 0);
        check1("R7 retake after hold-off", owner, 1'b1);

        // Release again with a slow enable: release still one core clock.
        step(1, 1, 1, 1, 0, 0);
        step(0, 1, 1, 1, 0, 1);
        check1("R1 done ignored off enable", owner, 1'b1);
        step(1, 1, 1, 1, 0, 1);
        check1("R6 release", busy_oe & busy_out_n, 1'b1);
        step(0, 1, 1, 1, 0, 0);
        check1("R6 one core clock on slow enable", busy_oe, 1'b0);
        step(1, 1, 1, 1, 0, 0);
        // R2: blocked by another master's busy, then by a transfer-start.
        step(1, 0, 1, 0, 1, 0);
        check1("R2 blocked by busy_in_n", owner, 1'b0);
        step(1, 0, 0, 1, 1, 0);
        check1("R2 blocked by ts_in_n", owner, 1'b0);
        step(1, 1, 1, 1, 1, 0);
        check1("R2 blocked without grant", owner, 1'b0);
        step(1, 0, 1, 1, 1, 0);
        check1("R2 taken when free", owner, 1'b1);

        // Randomized run against the model.
        for (int i = 0; i < 6000; i++) begin
            logic ce, gn, tsn, bsn, rq, dn;
            ce  = ($urandom % 3) != 0;
            gn  = ($urandom % 4) == 0;
            tsn = ($urandom % 5) != 0;
            bsn = ($urandom % 4) != 0;
            rq  = ($urandom % 2) == 0;
            dn  = ($urandom % 3) == 0;
            step(ce, gn, tsn, bsn, rq, dn);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule